// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command side of a NOR-style flash device together with a small word array held in flops. A host drives an asynchronous parallel bus: active-low chip select, output enable, write strobe and power-down pins, plus an address and a 16-bit data word. The block samples these pins on its system clock. Bytes written to it are commands that change what a read returns. A read can return array contents, a two-word identifier or a status byte. Other commands start internally timed word programs and block erases.

The state machine has six states:
- ST_RESET: entered whenever the power-down pin is sampled low.
- ST_READY: idle.
- ST_PROG_SETUP: waiting for the address and data word after a program command.
- ST_ERASE_SETUP: waiting for the confirm byte after an erase command.
- ST_PROG_BUSY: running a program.
- ST_ERASE_BUSY: running an erase.

The transitions are:
- ST_RESET to ST_READY when the power-down pin is released.
- ST_READY to ST_PROG_SETUP on command 40h.
- ST_READY to ST_ERASE_SETUP on command 20h.
- ST_PROG_SETUP to ST_PROG_BUSY on the next accepted write.
- ST_ERASE_SETUP to ST_ERASE_BUSY on D0h.
- ST_ERASE_SETUP to ST_READY on any other byte, which also flags a sequence error.
- ST_PROG_BUSY and ST_ERASE_BUSY to ST_READY when their cycle counts expire.
- Any state to ST_RESET when the power-down pin is sampled low.

After the power-down pin rises, a wake-up timer holds off reads for one count and command writes for a second count.

Top module: `flash_cui_ctrl`

## Requirements
- R1: After the system reset or a power-down release, a read returns array contents. Every word of the array reads FFFFh after the system reset.
- R2: The read mode changes only when a mode command is written. FFh selects array reads. 90h selects identifier reads, which return MFR_CODE at address 0, DEV_CODE at address 1 and 0000h at any other address. 70h selects status reads, where the status byte is on bits 7:0 and bits 15:8 are zero.
- R3: The data outputs are enabled (dq_oe=1) only while chip select and output enable are low, the write strobe is high and the power-down pin is high. Otherwise dq_oe is 0 and dq_out is 0000h.
- R4: With chip select high, the outputs stay disabled whatever the output enable pin does. A program that is already running still completes.
- R5: While the power-down pin is low, the outputs are disabled. On release, the read mode is array and the status byte is 80h.
- R6: If the power-down pin goes low during a program, the target word becomes GARBAGE. If it goes low during an erase, every word of the target block becomes GARBAGE.
- R7: A program is started by 40h followed by a write that carries the address and data. After PROG_CYC cycles the word becomes old AND data. Status bit 7 reads 0 while the program is busy and 1 when it is done. Reads show status from the program command on.
- R8: An erase is started by 20h followed by D0h written to any address in the block. A block is 2^BLK_W consecutive words, selected by the upper address bits. After ERASE_CYC cycles every word of that block reads FFFFh, and other blocks are unchanged.
- R9: After the power-down pin rises, dq_oe stays 0 for WAKE_RD cycles. Command writes are ignored for WAKE_WR cycles.
- R10: A command is taken once per write pulse, with chip select and write strobe low and output enable high. It is latched when the first of chip select or write strobe rises.
- R11: Any byte other than D0h after 20h returns the block to idle, sets status bit 5 (status reads A0h) and leaves the array unchanged. Command 50h clears bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Power-up reset, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| pwr_dn_n | input | 1 | Reset / deep power-down, active low |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data or command written by the host |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Output drive enable for the data bus |

## Verification
The bench builds the block with PROG_CYC=5 and ERASE_CYC=12, so a status read taken right after the second command word lands inside the busy window. It uses WAKE_RD=3 and WAKE_WR=6, so one power-down release can test the read hold-off, and a write issued straight after another release falls inside the write hold-off. With a 64-word array and BLK_W=4, the bench has four blocks. That lets it erase one block, confirm that a neighbouring block keeps its programmed value, and abort an erase in a third block.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_READY,
        ST_PROG_SETUP,
        ST_ERASE_SETUP,
        ST_PROG_BUSY,
        ST_ERASE_BUSY
    } fsm_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS
    } rmode_t;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_IDENT = 8'h90;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_PROGRAM    = 8'h40;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

endpackage

// File: rtl/flash_cui_sampler.sv
module flash_cui_sampler #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel_n,
    input  logic          out_en_n,
    input  logic          wr_strobe_n,
    input  logic          pwr_dn_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic          s_cs_n,
    output logic          s_oe_n,
    output logic          s_we_n,
    output logic          s_pd_n,
    output logic [AW-1:0] s_addr,
    output logic          cmd_stb,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data
);

    logic [DW-1:0] s_dq;
    logic          wr_act;
    logic          wr_act_d;

    // A write cycle is live while select and strobe are both low with output enable high.
    assign wr_act  = !s_cs_n && !s_we_n && s_oe_n && s_pd_n;
    // The command lands when the first of select or strobe goes high.
    assign cmd_stb = wr_act_d && !wr_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_cs_n   <= 1'b1;
            s_oe_n   <= 1'b1;
            s_we_n   <= 1'b1;
            s_pd_n   <= 1'b0;
            s_addr   <= '0;
            s_dq     <= '0;
            wr_act_d <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            s_cs_n   <= chip_sel_n;
            s_oe_n   <= out_en_n;
            s_we_n   <= wr_strobe_n;
            s_pd_n   <= pwr_dn_n;
            s_addr   <= addr;
            s_dq     <= dq_in;
            wr_act_d <= wr_act;
            if (wr_act) begin
                cmd_addr <= s_addr;
                cmd_data <= s_dq;
            end
        end
    end

    // R10
    one_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

endmodule

// File: rtl/flash_cui_wake.sv
module flash_cui_wake #(
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic rd_ok,
    output logic wr_ok
);

    localparam int MX = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CW = $clog2(MX + 1);

    logic [1:0] ok;

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        localparam logic [CW-1:0] LD = (g == 0) ? CW'(RD_CYC) : CW'(WR_CYC);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= LD;
            end else if (!pd_n) begin
                cnt <= LD;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end

        assign ok[g] = pd_n && (cnt == '0);
    end

    assign rd_ok = ok[0];
    assign wr_ok = ok[1];

    // R9
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> !rd_ok && !wr_ok);

endmodule

// File: rtl/flash_cui_array.sv
module flash_cui_array #(
    parameter int AW    = 6,
    parameter int BLK_W = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic             wr_and,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             fill_en,
    input  logic [AW-BLK_W-1:0] fill_blk,
    input  logic [DW-1:0]    fill_val
);

    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] chk_old;

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (fill_en && (AW'(w) >> BLK_W) == AW'(fill_blk)) begin
                    mem[w] <= fill_val;
                end else if (wr_en && wr_addr == AW'(w)) begin
                    mem[w] <= wr_and ? (mem[w] & wr_data) : wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) chk_old <= mem[wr_addr];

    // R7
    prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_and && !fill_en) |=> ((mem[$past(wr_addr)] & ~chk_old) == '0));

endmodule

// File: rtl/flash_cui_ctrl.sv
module flash_cui_ctrl
    import flash_cui_pkg::*;
#(
    parameter int          AW        = 6,
    parameter int          BLK_W     = 4,
    parameter int          PROG_CYC  = 5,
    parameter int          ERASE_CYC = 12,
    parameter int          WAKE_RD   = 3,
    parameter int          WAKE_WR   = 6,
    parameter logic [15:0] GARBAGE   = 16'h5A5A,
    parameter logic [15:0] MFR_CODE  = 16'h00C3,
    parameter logic [15:0] DEV_CODE  = 16'h4E21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel_n,
    input  logic          out_en_n,
    input  logic          wr_strobe_n,
    input  logic          pwr_dn_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic          dq_oe
);

    localparam int DW = 16;
    localparam int MX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW = $clog2(MX + 1);
    localparam int BA = AW - BLK_W;

    logic          s_cs_n, s_oe_n, s_we_n, s_pd_n;
    logic [AW-1:0] s_addr, cmd_addr;
    logic          cmd_stb;
    logic [DW-1:0] cmd_data;
    logic          rd_ok, wr_ok;

    fsm_t          state_q, state_d;
    rmode_t        mode_q;
    logic          err_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] op_addr_q;
    logic [DW-1:0] op_data_q;

    logic          accept;
    logic          busy;
    logic [7:0]    status;
    logic [DW-1:0] arr_rd;
    logic          wr_en, wr_and, fill_en;
    logic [DW-1:0] wr_data, fill_val;
    logic [DW-1:0] rd_val;

    flash_cui_sampler #(.AW(AW), .DW(DW)) u_smp (
        .clk(clk), .rst_n(rst_n),
        .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .wr_strobe_n(wr_strobe_n), .pwr_dn_n(pwr_dn_n),
        .addr(addr), .dq_in(dq_in),
        .s_cs_n(s_cs_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n), .s_pd_n(s_pd_n),
        .s_addr(s_addr), .cmd_stb(cmd_stb),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    flash_cui_wake #(.RD_CYC(WAKE_RD), .WR_CYC(WAKE_WR)) u_wake (
        .clk(clk), .rst_n(rst_n), .pd_n(s_pd_n),
        .rd_ok(rd_ok), .wr_ok(wr_ok)
    );

    flash_cui_array #(.AW(AW), .BLK_W(BLK_W), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(s_addr), .rd_data(arr_rd),
        .wr_en(wr_en), .wr_and(wr_and), .wr_addr(op_addr_q), .wr_data(wr_data),
        .fill_en(fill_en), .fill_blk(op_addr_q[AW-1:BLK_W]), .fill_val(fill_val)
    );

    assign accept = cmd_stb && wr_ok;
    assign busy   = (state_q == ST_PROG_BUSY) || (state_q == ST_ERASE_BUSY);
    assign status = {!busy, 1'b0, err_q, 5'b0};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:       if (s_pd_n) state_d = ST_READY;
            ST_READY: begin
                if (accept && cmd_data[7:0] == CMD_PROGRAM) state_d = ST_PROG_SETUP;
                else if (accept && cmd_data[7:0] == CMD_ERASE) state_d = ST_ERASE_SETUP;
            end
            ST_PROG_SETUP:  if (accept) state_d = ST_PROG_BUSY;
            ST_ERASE_SETUP: if (accept) state_d = (cmd_data[7:0] == CMD_CONFIRM) ? ST_ERASE_BUSY : ST_READY;
            ST_PROG_BUSY:   if (cnt_q == CW'(1)) state_d = ST_READY;
            ST_ERASE_BUSY:  if (cnt_q == CW'(1)) state_d = ST_READY;
            default:        state_d = ST_RESET;
        endcase
        if (!s_pd_n) state_d = ST_RESET;
    end

    // State register and the registers tied to it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RESET;
            mode_q    <= RM_ARRAY;
            err_q     <= 1'b0;
            cnt_q     <= '0;
            op_addr_q <= '0;
            op_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (!s_pd_n) begin
                mode_q <= RM_ARRAY;
                err_q  <= 1'b0;
            end else begin
                if (busy && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                unique case (state_q)
                    ST_READY: if (accept) begin
                        unique case (cmd_data[7:0])
                            CMD_READ_ARRAY: mode_q <= RM_ARRAY;
                            CMD_READ_IDENT: mode_q <= RM_IDENT;
                            CMD_READ_STAT:  mode_q <= RM_STATUS;
                            CMD_CLR_STAT:   err_q  <= 1'b0;
                            CMD_PROGRAM,
                            CMD_ERASE:      mode_q <= RM_STATUS;
                            default:        ;
                        endcase
                    end
                    ST_PROG_SETUP: if (accept) begin
                        op_addr_q <= cmd_addr;
                        op_data_q <= cmd_data;
                        cnt_q     <= CW'(PROG_CYC);
                    end
                    ST_ERASE_SETUP: if (accept) begin
                        op_addr_q <= cmd_addr;
                        cnt_q     <= CW'(ERASE_CYC);
                        if (cmd_data[7:0] != CMD_CONFIRM) err_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs: array write controls and read data
    always_comb begin
        wr_en    = (state_q == ST_PROG_BUSY) && (!s_pd_n || cnt_q == CW'(1));
        wr_and   = s_pd_n;
        wr_data  = s_pd_n ? op_data_q : GARBAGE;
        fill_en  = (state_q == ST_ERASE_BUSY) && (!s_pd_n || cnt_q == CW'(1));
        fill_val = s_pd_n ? '1 : GARBAGE;
        unique case (mode_q)
            RM_IDENT:  rd_val = (s_addr == '0) ? MFR_CODE :
                                (s_addr == AW'(1)) ? DEV_CODE : '0;
            RM_STATUS: rd_val = {8'h00, status};
            default:   rd_val = arr_rd;
        endcase
        dq_oe  = !s_cs_n && !s_oe_n && s_we_n && s_pd_n && rd_ok;
        dq_out = dq_oe ? rd_val : '0;
    end

    // R5
    rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_pd_n) |-> (mode_q == RM_ARRAY) && (status == 8'h80));

    // R7
    prog_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_BUSY && s_pd_n && cnt_q != CW'(1)) |=> state_q == ST_PROG_BUSY);

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_pd_n) |=> state_q == ST_RESET);

    // R8
    erase_only_after_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |=> state_q != ST_ERASE_BUSY);

endmodule

// File: tb/flash_cui_ctrl_bench.sv
module flash_cui_ctrl_bench;

    localparam int          AW      = 6;
    localparam logic [15:0] GARB    = 16'h5A5A;
    localparam logic [15:0] MFR     = 16'h00C3;
    localparam logic [15:0] DEV     = 16'h4E21;
    localparam int          WAKE_RD = 3;

    localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_RDY = 2'd2;
    localparam int NV = 43;
    // {req, kind, addr, data, expected}
    localparam logic [43:0] VEC [NV] = '{
        {4'd1,  K_R,   6'd5,  16'h0000, 16'hFFFF}, // R1 array after reset
        {4'd2,  K_W,   6'd0,  16'h0090, 16'h0000}, // R2 ident
        {4'd2,  K_R,   6'd0,  16'h0000, MFR},
        {4'd2,  K_R,   6'd1,  16'h0000, DEV},
        {4'd2,  K_R,   6'd2,  16'h0000, 16'h0000},
        {4'd2,  K_W,   6'd0,  16'h0070, 16'h0000}, // R2 status
        {4'd2,  K_R,   6'd0,  16'h0000, 16'h0080},
        {4'd2,  K_W,   6'd0,  16'h00FF, 16'h0000},
        {4'd2,  K_R,   6'd3,  16'h0000, 16'hFFFF},
        {4'd7,  K_W,   6'd3,  16'h0040, 16'h0000}, // R7 program
        {4'd7,  K_W,   6'd3,  16'h12F0, 16'h0000},
        {4'd7,  K_R,   6'd3,  16'h0000, 16'h0000},
        {4'd7,  K_RDY, 6'd0,  16'h0000, 16'h0080},
        {4'd7,  K_W,   6'd0,  16'h00FF, 16'h0000},
        {4'd7,  K_R,   6'd3,  16'h0000, 16'h12F0},
        {4'd7,  K_W,   6'd3,  16'h0040, 16'h0000}, // R7 bits only clear
        {4'd7,  K_W,   6'd3,  16'h0FFF, 16'h0000},
        {4'd7,  K_RDY, 6'd0,  16'h0000, 16'h0080},
        {4'd7,  K_W,   6'd0,  16'h00FF, 16'h0000},
        {4'd7,  K_R,   6'd3,  16'h0000, 16'h02F0},
        {4'd8,  K_W,   6'd19, 16'h0040, 16'h0000}, // R8 prepare block 1
        {4'd8,  K_W,   6'd19, 16'h0000, 16'h0000},
        {4'd8,  K_RDY, 6'd0,  16'h0000, 16'h0080},
        {4'd8,  K_W,   6'd0,  16'h00FF, 16'h0000},
        {4'd8,  K_R,   6'd19, 16'h0000, 16'h0000},
        {4'd8,  K_W,   6'd16, 16'h0020, 16'h0000}, // R8 erase block 1
        {4'd8,  K_W,   6'd18, 16'h00D0, 16'h0000},
        {4'd8,  K_R,   6'd0,  16'h0000, 16'h0000},
        {4'd8,  K_RDY, 6'd0,  16'h0000, 16'h0080},
        {4'd8,  K_W,   6'd0,  16'h00FF, 16'h0000},
        {4'd8,  K_R,   6'd19, 16'h0000, 16'hFFFF},
        {4'd8,  K_R,   6'd3,  16'h0000, 16'h02F0},
        {4'd11, K_W,   6'd0,  16'h0020, 16'h0000}, // R11 bad confirm
        {4'd11, K_W,   6'd0,  16'h0033, 16'h0000},
        {4'd11, K_R,   6'd0,  16'h0000, 16'h00A0},
        {4'd11, K_W,   6'd0,  16'h0050, 16'h0000},
        {4'd11, K_R,   6'd0,  16'h0000, 16'h0080},
        {4'd11, K_W,   6'd0,  16'h00FF, 16'h0000},
        {4'd11, K_R,   6'd3,  16'h0000, 16'h02F0},
        {4'd11, K_R,   6'd0,  16'h0000, 16'hFFFF},
        {4'd2,  K_W,   6'd0,  16'h0033, 16'h0000}, // R2 unknown byte keeps mode
        {4'd2,  K_R,   6'd3,  16'h0000, 16'h02F0},
        {4'd2,  K_R,   6'd1,  16'h0000, 16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1, out_en_n = 1'b1, wr_strobe_n = 1'b1, pwr_dn_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic          dq_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_cui_ctrl #(.AW(AW), .BLK_W(4), .PROG_CYC(5), .ERASE_CYC(12),
                     .WAKE_RD(WAKE_RD), .WAKE_WR(6), .GARBAGE(GARB),
                     .MFR_CODE(MFR), .DEV_CODE(DEV)) u_flash_cui_ctrl (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .wr_strobe_n(wr_strobe_n), .pwr_dn_n(pwr_dn_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        chip_sel_n = 1'b0; wr_strobe_n = 1'b0; out_en_n = 1'b1; addr = a; dq_in = d;
        @(negedge clk);
        chip_sel_n = 1'b1; wr_strobe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d, output logic oe);
        chip_sel_n = 1'b0; out_en_n = 1'b0; wr_strobe_n = 1'b1; addr = a;
        @(negedge clk);
        d = dq_out; oe = dq_oe;
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_check(input string tag, input logic [AW-1:0] a, input logic [15:0] exp);
        logic [15:0] d;
        logic oe;
        bus_read(a, d, oe);
        check({tag, " oe"}, {15'd0, oe}, 16'd1);
        check(tag, d, exp);
    endtask

    task automatic wait_ready(input string tag);
        logic [15:0] d;
        logic oe;
        d = '0;
        for (int k = 0; k < 60 && !d[7]; k++) bus_read(6'd0, d, oe);
        check(tag, d, 16'h0080);
    endtask

    task automatic power_cycle(input int hold, input int after);
        @(negedge clk);
        pwr_dn_n = 1'b0;
        repeat (hold) @(negedge clk);
        pwr_dn_n = 1'b1;
        repeat (after) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic oe;
        // R1 reset state: outputs off while reset held
        repeat (3) @(negedge clk);
        chip_sel_n = 1'b0; out_en_n = 1'b0;
        @(negedge clk);
        check("R3 oe during reset", {15'd0, dq_oe}, 16'd0);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        rst_n = 1'b1;
        repeat (15) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vector %0d", v[43:40], i);
            unique case (v[39:38])
                K_W:     bus_write(v[37:32], v[31:16]);
                K_R:     read_check(tag, v[37:32], v[15:0]);
                default: wait_ready(tag);
            endcase
        end

        // R3: output enable high keeps outputs off; strobe low blocks a read
        chip_sel_n = 1'b0; out_en_n = 1'b1;
        @(negedge clk);
        check("R3 oe with out_en high", {15'd0, dq_oe}, 16'd0);
        out_en_n = 1'b0; wr_strobe_n = 1'b0;
        @(negedge clk);
        check("R3 oe with strobe low", {15'd0, dq_oe}, 16'd0);
        chip_sel_n = 1'b1; out_en_n = 1'b1; wr_strobe_n = 1'b1;
        @(negedge clk);

        // R4: standby during a program; the program still finishes
        bus_write(6'd9, 16'h0040);
        bus_write(6'd9, 16'h00FF);
        chip_sel_n = 1'b1; out_en_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 standby oe", {15'd0, dq_oe}, 16'd0);
        out_en_n = 1'b1;
        repeat (12) @(negedge clk);
        read_check("R4 status after standby", 6'd0, 16'h0080);
        bus_write(6'd0, 16'h00FF);
        read_check("R4 word programmed", 6'd9, 16'h00FF);

        // R6 / R5: abort a program
        bus_write(6'd7, 16'h0040);
        bus_write(6'd7, 16'h0000);
        @(negedge clk);
        pwr_dn_n = 1'b0;
        chip_sel_n = 1'b0; out_en_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 oe while powered down", {15'd0, dq_oe}, 16'd0);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        pwr_dn_n = 1'b1;
        repeat (12) @(negedge clk);
        read_check("R6 aborted word", 6'd7, GARB);
        read_check("R5 neighbour word intact", 6'd9, 16'h00FF);
        bus_write(6'd0, 16'h0070);
        read_check("R5 status after release", 6'd0, 16'h0080);
        bus_write(6'd0, 16'h00FF);

        // R6: abort an erase of block 2
        bus_write(6'd33, 16'h0020);
        bus_write(6'd33, 16'h00D0);
        power_cycle(3, 12);
        read_check("R6 aborted block first", 6'd32, GARB);
        read_check("R6 aborted block last", 6'd47, GARB);
        read_check("R6 other block intact", 6'd3, 16'h02F0);

        // R9: read hold-off after release
        @(negedge clk);
        pwr_dn_n = 1'b0;
        repeat (3) @(negedge clk);
        pwr_dn_n = 1'b1;
        chip_sel_n = 1'b0; out_en_n = 1'b0; addr = 6'd3;
        @(negedge clk);
        check("R9 read held off", {15'd0, dq_oe}, 16'd0);
        repeat (WAKE_RD + 2) @(negedge clk);
        check("R9 read allowed", {15'd0, dq_oe}, 16'd1);
        check("R9 read data", dq_out, 16'h02F0);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        @(negedge clk);

        // R9: write hold-off, an ident command right after release is dropped
        @(negedge clk);
        pwr_dn_n = 1'b0;
        repeat (3) @(negedge clk);
        pwr_dn_n = 1'b1;
        bus_write(6'd0, 16'h0090);
        repeat (10) @(negedge clk);
        read_check("R9 early write ignored", 6'd0, 16'hFFFF);

        // R10: a long write pulse still gives one command
        bus_write(6'd0, 16'h0090);
        read_check("R10 command taken", 6'd1, DEV);
        @(negedge clk);
        chip_sel_n = 1'b0; wr_strobe_n = 1'b0; dq_in = 16'h0070;
        repeat (4) @(negedge clk);
        chip_sel_n = 1'b1;
        @(negedge clk);
        wr_strobe_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(6'd0, d, oe);
        check("R10 select-first release latches", d, 16'h0080);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule